// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds a set of wide event counters that software programs and reads through a plain 32-bit register port. Each counter is given an 8-bit event code. On every clock the counter looks up its code in a vector of single-cycle event pulses and adds one when the selected pulse is high. A counter can only advance when its own enable bit and the shared global enable bit are both set. While the global enable is clear, every counter keeps its value, and software can still load it.

When a counter passes from all ones back to zero, it sets a sticky status bit. A mask register decides which status bits reach the single interrupt line. Software clears a status bit by writing a one to the matching bit of a separate clear register. A read-only version word identifies the block.

Register reads take one clock: the read data register loads on the edge that samples the read strobe.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous active-high reset, all of the following hold: every counter reads zero, the control register reads zero, the status register reads zero, all mask bits read one, and `irq` and `reg_rdata` are zero.
- R2: Counter n advances by exactly one on each clock where all three of these hold: its selected event pulse is high, bit n of the control register (offset 0x1C00, bits [7:0]) is set, and the global enable (bit 26 of that register) is set. If either enable is clear, the counter holds its value.
- R3: The event code of counter n is byte lane n%4 of the select register at 0x1D00 + 4*(n/4), that is bits [8*(n%4)+7 : 8*(n%4)]. Code c selects `evt_in[c]`.
- R4: An event code equal to or greater than the width of `evt_in` never makes its counter advance.
- R5: The low 32 bits of counter n sit at offset 0x1E00 + 8*n and the high 32 bits at 0x1E00 + 8*n + 4. A write to one half leaves the other half unchanged. Counter writes take effect whether or not the global enable is set.
- R6: When a software write to a counter half and a counted event fall on the same clock, the written value is kept and the event is not added.
- R7: When a counter advances from all ones to zero, its bit in the status register (0x808) becomes one.
- R8: Writing to the clear register (0x80C) clears exactly those status bits whose written bit is one. Zero bits in that write have no effect. Writes to the status register itself have no effect.
- R9: `irq` is one on the clock after any status bit is set while its mask bit (register 0x800) is clear. A set mask bit keeps its status bit from raising `irq`.
- R10: The version register at 0x1CF0 always reads the `VERSION` parameter. Writes to it have no effect.
- R11: `reg_rdata` loads on the clock edge that samples `reg_rd`. Unmapped offsets read zero. The control register reads zero in every bit other than [7:0] and 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | NUM_EVT | Single-cycle event pulses, indexed by event code |
| irq | output | 1 | Interrupt, high while an unmasked status bit is set |

## Verification
The counting path is driven with four kinds of event patterns, each of which separates a different fault:
- Pulses on one event line at a time confirm that each byte lane routes the correct code to the correct counter.
- All event lines held high together show that an out-of-range code stays silent while the other counters still advance.
- Repeating that burst with only one counter enabled, and then with only the global enable cleared, separates the two levels of gating.
- Loading a counter with all ones, and a write that collides with an event, exercise the wrap into the status bit and the priority of the write.

A reference model in the bench tracks every register on each clock and checks both the read data and the interrupt line against it.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int DATA_W    = 32;
  localparam int LANE_W    = 8;
  localparam int LANES     = DATA_W / LANE_W;
  localparam int GLB_BIT   = 26;
  localparam int OFF_MASK  = 'h0800;
  localparam int OFF_STAT  = 'h0808;
  localparam int OFF_CLR   = 'h080C;
  localparam int OFF_CTRL  = 'h1C00;
  localparam int OFF_VER   = 'h1CF0;
  localparam int OFF_SEL   = 'h1D00;
  localparam int OFF_CTR   = 'h1E00;
endpackage

// File: rtl/pcb_ctr_slice.sv
module pcb_ctr_slice #(
  parameter int CTR_W   = 64,
  parameter int NUM_EVT = 32,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic [CODE_W-1:0]  code,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [31:0]        wdata,
  output logic [CTR_W-1:0]   cnt_q,
  output logic               wrap
);
  localparam int SPAN = 1 << CODE_W;
  localparam int HI_W = CTR_W - 32;

  logic [SPAN-1:0] evt_ext;
  logic            hit;
  logic            inc;
  logic            sw_wr;

  // Zero-extend the pulse vector so that any code past its width reads 0.
  assign evt_ext = SPAN'(evt_in);
  assign hit     = evt_ext[code];
  assign inc     = cnt_en && hit;
  assign sw_wr   = wr_lo || wr_hi;
  assign wrap    = inc && !sw_wr && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (sw_wr) begin
      if (wr_lo) cnt_q[31:0]      <= wdata;
      if (wr_hi) cnt_q[CTR_W-1:32] <= wdata[HI_W-1:0];
    end else if (inc) begin
      cnt_q <= cnt_q + CTR_W'(1);
    end
  end
endmodule

// File: rtl/pcb_irq.sv
module pcb_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] wrap,
  input  logic         mask_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] status_q,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      // A new wrap wins over a clear in the same cycle.
      status_q <= (status_q & ~clr_bits) | wrap;
      if (mask_wr) mask_q <= wbits;
      irq_q <= |(status_q & ~mask_q);
    end
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int          NUM_CTR = 8,
  parameter int          CTR_W   = 64,
  parameter int          NUM_EVT = 32,
  parameter int          ADDR_W  = 16,
  parameter logic [31:0] VERSION = 32'h0000_0200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);
  localparam int NUM_SEL = (NUM_CTR + LANES - 1) / LANES;

  logic [NUM_CTR-1:0]       ctr_en_q;
  logic                     glb_en_q;
  logic [31:0]              evsel_q [NUM_SEL];
  logic [CTR_W-1:0]         cnt_q   [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic [NUM_CTR-1:0]       wr_lo, wr_hi, wrap_vec;
  logic [NUM_CTR-1:0]       status_q, mask_q;
  logic                     irq_q;
  logic [31:0]              rd_mux;
  logic                     ctrl_wr, mask_wr, clr_wr;
  logic                     unused_wbits;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
  assign mask_wr = reg_wr && (reg_addr == ADDR_W'(OFF_MASK));
  assign clr_wr  = reg_wr && (reg_addr == ADDR_W'(OFF_CLR));
  assign unused_wbits = ^{reg_wdata[31:GLB_BIT+1], reg_wdata[GLB_BIT-1:NUM_CTR]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_en_q <= '0;
      glb_en_q <= 1'b0;
      for (int k = 0; k < NUM_SEL; k++) evsel_q[k] <= '0;
    end else begin
      if (ctrl_wr) begin
        ctr_en_q <= reg_wdata[NUM_CTR-1:0];
        glb_en_q <= reg_wdata[GLB_BIT];
      end
      for (int k = 0; k < NUM_SEL; k++)
        if (reg_wr && reg_addr == ADDR_W'(OFF_SEL + 4*k)) evsel_q[k] <= reg_wdata;
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    localparam int SEL_IDX = n / LANES;
    localparam int LANE    = n % LANES;
    assign wr_lo[n] = reg_wr && (reg_addr == ADDR_W'(OFF_CTR + 8*n));
    assign wr_hi[n] = reg_wr && (reg_addr == ADDR_W'(OFF_CTR + 8*n + 4));

    pcb_ctr_slice #(
      .CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .CODE_W(LANE_W)
    ) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .cnt_en (glb_en_q && ctr_en_q[n]),
      .code   (evsel_q[SEL_IDX][LANE*LANE_W +: LANE_W]),
      .evt_in (evt_in),
      .wr_lo  (wr_lo[n]),
      .wr_hi  (wr_hi[n]),
      .wdata  (reg_wdata),
      .cnt_q  (cnt_q[n]),
      .wrap   (wrap_vec[n])
    );
    assign cnt_flat[n*CTR_W +: CTR_W] = cnt_q[n];
  end

  pcb_irq #(.N(NUM_CTR)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap_vec),
    .mask_wr  (mask_wr),
    .clr_wr   (clr_wr),
    .wbits    (reg_wdata[NUM_CTR-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_q    (irq_q)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFF_MASK)) rd_mux = 32'(mask_q);
    if (reg_addr == ADDR_W'(OFF_STAT)) rd_mux = 32'(status_q);
    if (reg_addr == ADDR_W'(OFF_CTRL))
      rd_mux = 32'(ctr_en_q) | (32'(glb_en_q) << GLB_BIT);
    if (reg_addr == ADDR_W'(OFF_VER)) rd_mux = VERSION;
    for (int k = 0; k < NUM_SEL; k++)
      if (reg_addr == ADDR_W'(OFF_SEL + 4*k)) rd_mux = evsel_q[k];
    for (int n = 0; n < NUM_CTR; n++) begin
      if (reg_addr == ADDR_W'(OFF_CTR + 8*n))     rd_mux = cnt_q[n][31:0];
      if (reg_addr == ADDR_W'(OFF_CTR + 8*n + 4)) rd_mux = 32'(cnt_q[n][CTR_W-1:32]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign irq = irq_q;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64,
  parameter int ADDR_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [31:0]              wdata,
  input logic                     glb_en,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
  input logic [NUM_CTR-1:0]       status,
  input logic [NUM_CTR-1:0]       mask,
  input logic                     irq
);
  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1 && status == '0 && !irq && cnt_flat == '0))
    else $error("rst_state_chk");

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !wr_en) |=> $stable(cnt_flat))
    else $error("hold_chk");

  // R9
  mask_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (mask == '1) |=> !irq)
    else $error("mask_irq_chk");

  // R9
  idle_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> !irq)
    else $error("idle_irq_chk");

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_bit
    // R7
    wrap_status_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(status[n]) |-> (cnt_flat[n*CTR_W +: CTR_W] == '0 &&
                            $past(cnt_flat[n*CTR_W +: CTR_W]) == '1))
      else $error("wrap_status_chk");

    // R8
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(status[n]) |-> $past(wr_en && addr == ADDR_W'(OFF_CLR) && wdata[n]))
      else $error("clear_only_chk");
  end
endmodule

bind perf_counter_bank pcb_checker #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (reg_wr),
  .addr     (reg_addr),
  .wdata    (reg_wdata),
  .glb_en   (glb_en_q),
  .cnt_flat (cnt_flat),
  .status   (status_q),
  .mask     (mask_q),
  .irq      (irq)
);

// File: tb/perf_counter_bank_tb_top.sv
module perf_counter_bank_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NC   = 8;
  localparam int          NE   = 32;
  localparam logic [31:0] VER  = 32'h0000_0200;
  localparam logic [15:0] A_MASK = 16'h0800, A_STAT = 16'h0808, A_CLR = 16'h080C;
  localparam logic [15:0] A_CTRL = 16'h1C00, A_VER = 16'h1CF0, A_SEL = 16'h1D00;
  localparam logic [15:0] A_CTR  = 16'h1E00;
  localparam logic [31:0] GLB = 32'h0400_0000;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NE-1:0] evt_in = '0;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_bank dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
  );

  // Behavioural reference model
  logic [63:0] m_cnt [NC];
  logic [31:0] m_sel [2];
  logic [7:0]  m_en, m_status, m_mask;
  logic        m_glb, m_irq;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [15:0] a);
    if (a == A_MASK) return {24'd0, m_mask};
    if (a == A_STAT) return {24'd0, m_status};
    if (a == A_CTRL) return {24'd0, m_en} | (m_glb ? GLB : 32'd0);
    if (a == A_VER)  return VER;
    if (a == A_SEL)  return m_sel[0];
    if (a == A_SEL + 16'd4) return m_sel[1];
    for (int n = 0; n < NC; n++) begin
      if (a == A_CTR + 16'(8*n))     return m_cnt[n][31:0];
      if (a == A_CTR + 16'(8*n + 4)) return m_cnt[n][63:32];
    end
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NC; n++) m_cnt[n] = 64'd0;
      m_sel[0] = 0; m_sel[1] = 0; m_en = 0; m_glb = 0;
      m_status = 0; m_mask = 8'hFF; m_irq = 0; m_rdata = 0;
    end else begin
      logic [7:0] wraps;
      wraps = 0;
      if (reg_rd) m_rdata = m_read(reg_addr);
      m_irq = |(m_status & ~m_mask);
      for (int n = 0; n < NC; n++) begin
        int code;
        logic hit;
        code = int'(m_sel[n/4][8*(n%4) +: 8]);
        hit  = (code < NE) ? evt_in[code] : 1'b0;
        if (reg_wr && reg_addr == A_CTR + 16'(8*n))          m_cnt[n][31:0]  = reg_wdata;
        else if (reg_wr && reg_addr == A_CTR + 16'(8*n + 4)) m_cnt[n][63:32] = reg_wdata;
        else if (m_glb && m_en[n] && hit) begin
          if (m_cnt[n] == '1) wraps[n] = 1'b1;
          m_cnt[n] = m_cnt[n] + 64'd1;
        end
      end
      m_status = (m_status & ~((reg_wr && reg_addr == A_CLR) ? reg_wdata[7:0] : 8'd0)) | wraps;
      if (reg_wr && reg_addr == A_MASK) m_mask = reg_wdata[7:0];
      if (reg_wr && reg_addr == A_CTRL) begin m_en = reg_wdata[7:0]; m_glb = reg_wdata[26]; end
      if (reg_wr && reg_addr == A_SEL) m_sel[0] = reg_wdata;
      if (reg_wr && reg_addr == A_SEL + 16'd4) m_sel[1] = reg_wdata;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R11 read data, R9 interrupt)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R11 rdata vs model", 64'(reg_rdata), 64'(m_rdata));
      check("R9 irq vs model", 64'(irq), 64'(m_irq));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] v, input int cycles);
    @(negedge clk); evt_in = v;
    repeat (cycles) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", 64'(irq), 64'd0);
    rd(A_MASK, d); check("R1 mask", 64'(d), 64'hFF);
    rd(A_STAT, d); check("R1 status", 64'(d), 64'h0);
    rd(A_CTRL, d); check("R1 ctrl", 64'(d), 64'h0);
    rd(A_CTR + 16'd8, d); check("R1 counter", 64'(d), 64'h0);
    // R10 version
    rd(A_VER, d); check("R10 version", 64'(d), 64'(VER));
    wr(A_VER, 32'h1234_5678);
    rd(A_VER, d); check("R10 version after write", 64'(d), 64'(VER));
    // R11 unmapped
    rd(16'h0100, d); check("R11 unmapped", 64'(d), 64'h0);
    // R3 lane routing, R4 out-of-range code
    wr(A_SEL, 32'h0302_0100);
    wr(A_SEL + 16'd4, 32'h2805_0505);
    wr(A_CTRL, GLB | 32'hFF);
    pulse(32'h1, 5);
    pulse(32'h2, 3);
    pulse(32'h20, 2);
    pulse('1, 4);
    rd(A_CTR, d);          check("R3 ctr0", 64'(d), 64'd9);
    rd(A_CTR + 16'd8, d);  check("R3 ctr1", 64'(d), 64'd7);
    rd(A_CTR + 16'd16, d); check("R2 ctr2", 64'(d), 64'd4);
    rd(A_CTR + 16'd32, d); check("R3 ctr4", 64'(d), 64'd6);
    rd(A_CTR + 16'd56, d); check("R4 ctr7 code beyond width", 64'(d), 64'd0);
    // R2 per-counter enable
    wr(A_CTRL, GLB | 32'h01);
    pulse('1, 3);
    rd(A_CTR, d);         check("R2 ctr0 enabled", 64'(d), 64'd12);
    rd(A_CTR + 16'd8, d); check("R2 ctr1 disabled", 64'(d), 64'd7);
    // R2 global enable
    wr(A_CTRL, 32'hFF);
    pulse('1, 3);
    rd(A_CTR, d);         check("R2 global clear holds", 64'(d), 64'd12);
    // R5 halves, writable with global enable clear
    wr(A_CTR + 16'd20, 32'hAAAA_5555);
    rd(A_CTR + 16'd16, d); check("R5 lo kept", 64'(d), 64'd4);
    rd(A_CTR + 16'd20, d); check("R5 hi written", 64'(d), 64'hAAAA_5555);
    wr(A_CTR + 16'd16, 32'h1234_5678);
    rd(A_CTR + 16'd16, d); check("R5 lo written", 64'(d), 64'h1234_5678);
    rd(A_CTR + 16'd20, d); check("R5 hi kept", 64'(d), 64'hAAAA_5555);
    // R6 write wins over event
    wr(A_CTRL, GLB | 32'h08);
    @(negedge clk); reg_wr = 1; reg_addr = A_CTR + 16'd24; reg_wdata = 32'd100; evt_in = 32'h8;
    @(negedge clk); reg_wr = 0; evt_in = '0;
    rd(A_CTR + 16'd24, d); check("R6 write priority", 64'(d), 64'd100);
    // R7 wrap, R9 unmasked interrupt
    wr(A_CTRL, 32'h0);
    wr(A_CTR + 16'd8, 32'hFFFF_FFFF);
    wr(A_CTR + 16'd12, 32'hFFFF_FFFF);
    wr(A_MASK, 32'hFD);
    check("R9 irq idle before wrap", 64'(irq), 64'd0);
    wr(A_CTRL, GLB | 32'h02);
    pulse(32'h2, 1);
    wr(A_CTRL, 32'h0);
    rd(A_CTR + 16'd8, d);  check("R7 wrapped lo", 64'(d), 64'd0);
    rd(A_CTR + 16'd12, d); check("R7 wrapped hi", 64'(d), 64'd0);
    rd(A_STAT, d);         check("R7 status bit", 64'(d), 64'h02);
    check("R9 irq raised", 64'(irq), 64'd1);
    // R9 masking
    wr(A_MASK, 32'hFF);
    rd(A_MASK, d); check("R9 mask readback", 64'(d), 64'hFF);
    check("R9 irq masked", 64'(irq), 64'd0);
    // R8 clear semantics
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R8 status write ignored", 64'(d), 64'h02);
    wr(A_CLR, 32'hFD);
    rd(A_STAT, d); check("R8 zero bit no effect", 64'(d), 64'h02);
    wr(A_CLR, 32'h02);
    rd(A_STAT, d); check("R8 cleared", 64'(d), 64'h00);
    // R11 reserved control bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R11 ctrl reserved", 64'(d), 64'h0400_00FF);
    wr(A_CTRL, 32'h0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule